// File: doc/BRIEF.md
# Four-channel supply status and reset sequencer

This block is the digital core of a supply supervisor. Each of four channels receives an under-voltage flag from an external comparator, and channels 3 and 4 also receive an over-voltage flag. The block turns these flags into four qualified status outputs and one system reset, which is driven on two complementary outputs. A status output goes to its valid level only after its channel has stayed good for a programmable number of clock cycles. It drops at once when the channel goes bad or its enable goes low.

A pairing mode takes the over-voltage flags of channels 3 and 4. Over-voltage on channel 3 then also makes status 1 not valid, and over-voltage on channel 4 does the same to status 2. In this mode statuses 3 and 4 are idle. The system reset is asserted at once on any of its causes. It is released only after a programmable timeout that runs through without interruption once all causes have cleared.

Top module: `supv_seq`

## Requirements
- R1: When en_i[k] is 0, status k is at its not-valid level whatever the flags are. That level is 0 for statuses 1 and 2 and is equal to inv_i for statuses 3 and 4 when pair_i is 0.
- R2: With pair_i=0, channel k (k=1..4) is good when en_i[k-1]=1 and uv_i[k-1]=0. No channel affects another channel's status.
- R3: With pair_i=1, channel 1 is good only when en_i[0]=1, uv_i[0]=0 and ov_i[0]=0. Channel 2 is good only when en_i[1]=1, uv_i[1]=0 and ov_i[1]=0.
- R4: With pair_i=1, stat_o[2] and stat_o[3] are 0 whatever the other inputs are.
- R5: With pair_i=0, stat_o[2] and stat_o[3] equal the qualified valid XOR inv_i, so they are high for valid when inv_i=0. stat_o[0] and stat_o[1] are never inverted.
- R6: A status turns valid once its channel has been good for dly_i[k] consecutive rising clock edges. When dly_i[k] is 0 it turns valid in the same cycle the channel becomes good.
- R7: A status leaves its valid level in the same cycle its channel stops being good, with no clock edge needed. Its delay count restarts from zero.
- R8: rst_o is 1 in the same cycle that any cause is present. The causes are: mrb_ni=0, any en_i bit 0, status 1 or 2 not valid, and (with pair_i=0) status 3 or 4 not valid.
- R9: With no cause present, rst_o falls after tmo_i+1 consecutive rising edges. Any cause during that time restarts the count from zero.
- R10: rst_no is always the complement of rst_o.
- R11: Out of the asynchronous reset rst_ni, rst_o is 1 and the timeout has to complete before it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 4 | Channel enables, active high |
| uv_i | input | 4 | Under-voltage flags per channel, 1 = under |
| ov_i | input | 2 | Over-voltage flags of channels 3 and 4, 1 = over |
| pair_i | input | 1 | Pairing mode: over-voltage of 3/4 qualifies 1/2 |
| inv_i | input | 1 | Output sense select for statuses 3 and 4 |
| mrb_ni | input | 1 | Manual reset request, active low |
| dly_i | input | 4 x DLY_W | Per-channel qualify delay in cycles |
| tmo_i | input | TMO_W | Reset release timeout (release after tmo_i+1 clean edges) |
| stat_o | output | 4 | Channel status outputs |
| rst_o | output | 1 | System reset, active high |
| rst_no | output | 1 | System reset, active low |

## Verification
The hardest case to reach is a cause that comes back after the reset timeout has partly elapsed. The stimulus releases the manual reset, lets a few edges pass, pulses it low for a single cycle, and then counts the full timeout again from the end of the pulse. It also checks that a delayed status falls in the same cycle its flag goes bad. With every delay set to zero, a full sweep of every flag, enable, mode and manual reset combination checks the status mapping and the reset causes against arithmetic expectations.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int unsigned NCH = 4;
  localparam int unsigned NOV = 2;
  typedef logic [NCH-1:0] chan_vec_t;
endpackage

// File: rtl/supv_map.sv
module supv_map
  import supv_pkg::*;
(
  input  chan_vec_t          en_i,
  input  chan_vec_t          uv_i,
  input  logic [NOV-1:0]     ov_i,
  input  logic               pair_i,
  output chan_vec_t          ok_o
);
  // channels 0/1 optionally qualified by over-voltage of 2/3; 2/3 idle when paired
  for (genvar k = 0; k < NCH; k++) begin : g_map
    if (k < NOV) begin : g_lo
      assign ok_o[k] = en_i[k] & ~uv_i[k] & ~(pair_i & ov_i[k]);
    end else begin : g_hi
      assign ok_o[k] = ~pair_i & en_i[k] & ~uv_i[k];
    end
  end
endmodule

// File: rtl/supv_chan_dly.sv
module supv_chan_dly #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ok_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             vld_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!ok_i)           cnt_q <= '0;
    else if (cnt_q < dly_i)   cnt_q <= cnt_q + 1'b1;
  end

  // combinational qualify so a bad input drops status with no edge
  assign vld_o = ok_i & (cnt_q >= dly_i);

  AST_CNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ok_i |=> cnt_q == '0); // R7
  AST_ROSE_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(vld_o) && dly_i != '0 && $stable(dly_i)) |-> $past(ok_i)); // R6
endmodule

// File: rtl/supv_rst_seq.sv
module supv_rst_seq #(
  parameter int unsigned TMO_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cause_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             rst_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cause_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q >= tmo_i) done_q <= 1'b1;
      else                cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign rst_o = cause_i | ~done_q;

  AST_CAUSE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |-> rst_o); // R8
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |=> (cnt_q == '0 && rst_o)); // R9
  AST_RELEASE_AFTER_TMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rst_o) && $stable(tmo_i)) |-> $past(cnt_q) >= $past(tmo_i)); // R9
endmodule

// File: rtl/supv_seq.sv
module supv_seq
  import supv_pkg::*;
#(
  parameter int unsigned DLY_W = 8,
  parameter int unsigned TMO_W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NCH-1:0]            en_i,
  input  logic [NCH-1:0]            uv_i,
  input  logic [NOV-1:0]            ov_i,
  input  logic                      pair_i,
  input  logic                      inv_i,
  input  logic                      mrb_ni,
  input  logic [NCH-1:0][DLY_W-1:0] dly_i,
  input  logic [TMO_W-1:0]          tmo_i,
  output logic [NCH-1:0]            stat_o,
  output logic                      rst_o,
  output logic                      rst_no
);
  chan_vec_t ok, vld;
  logic      cause, rst;

  supv_map i_map (
    .en_i   (en_i),
    .uv_i   (uv_i),
    .ov_i   (ov_i),
    .pair_i (pair_i),
    .ok_o   (ok)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    supv_chan_dly #(.DLY_W(DLY_W)) i_dly (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ok_i   (ok[k]),
      .dly_i  (dly_i[k]),
      .vld_o  (vld[k])
    );
    if (k < NOV) begin : g_plain
      assign stat_o[k] = vld[k];
    end else begin : g_sense
      assign stat_o[k] = pair_i ? 1'b0 : (vld[k] ^ inv_i);
    end
  end

  assign cause = ~mrb_ni | ~(&en_i) | ~(&vld[NOV-1:0])
               | (~pair_i & ~(&vld[NCH-1:NOV]));

  supv_rst_seq #(.TMO_W(TMO_W)) i_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cause_i (cause),
    .tmo_i   (tmo_i),
    .rst_o   (rst)
  );

  assign rst_o  = rst;
  assign rst_no = ~rst;

  AST_DIS_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&en_i) |-> rst_o); // R8
  AST_STAT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[0] |-> !stat_o[0]); // R1
  AST_MRB_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrb_ni |-> (rst_o && !rst_no)); // R8
endmodule

// File: tb/test_supv_seq.sv
module test_supv_seq;
  localparam int DW = 8;
  localparam int TW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] en, uv;
  logic [1:0] ov;
  logic pair, inv, mrb_n;
  logic [3:0][DW-1:0] dly;
  logic [TW-1:0] tmo;
  logic [3:0] stat;
  logic rst_o, rst_no;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  supv_seq #(.DLY_W(DW), .TMO_W(TW)) i_supv_seq (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .uv_i(uv), .ov_i(ov),
    .pair_i(pair), .inv_i(inv), .mrb_ni(mrb_n), .dly_i(dly), .tmo_i(tmo),
    .stat_o(stat), .rst_o(rst_o), .rst_no(rst_no)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk_pol();
    chk(rst_no == ~rst_o, "R10", rst_no, !rst_o);
  endtask

  task automatic all_good();
    en = 4'hF; uv = 4'h0; ov = 2'b00; pair = 1'b0; inv = 1'b0; mrb_n = 1'b1;
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    all_good();
    dly = '0; tmo = '0;
    #1;
    // R11 reset state
    chk(rst_o == 1'b1, "R11", rst_o, 1); chk_pol();
    tick(3);
    rst_n = 1'b1;
    tmo = 12'd3;
    #1;
    chk(rst_o == 1'b1, "R11", rst_o, 1);
    tick(3);
    chk(rst_o == 1'b1, "R11", rst_o, 1);
    tick(1);
    chk(rst_o == 1'b0, "R11", rst_o, 0); chk_pol();

    // exhaustive mapping sweep, zero delays and zero timeout
    tmo = '0;
    for (int v = 0; v < 8192; v++) begin
      logic [3:0] e, u; logic [1:0] o; logic p, iv, m;
      logic [3:0] ok, es; logic c;
      {m, iv, p, o, u, e} = 13'(v);
      en = e; uv = u; ov = o; pair = p; inv = iv; mrb_n = m;
      ok[0] = e[0] & ~u[0] & ~(p & o[0]);
      ok[1] = e[1] & ~u[1] & ~(p & o[1]);
      ok[2] = ~p & e[2] & ~u[2];
      ok[3] = ~p & e[3] & ~u[3];
      es[0] = ok[0]; es[1] = ok[1];
      es[2] = p ? 1'b0 : ok[2] ^ iv;
      es[3] = p ? 1'b0 : ok[3] ^ iv;
      c = ~m | (e != 4'hF) | ~ok[0] | ~ok[1] | (~p & (~ok[2] | ~ok[3]));
      #1;
      chk(stat == es, p ? (e != 4'hF ? "R1" : "R3/R4") : (iv ? "R5" : "R2"),
          stat, es);
      if (c) chk(rst_o == 1'b1, "R8", rst_o, 1);
      chk_pol();
      tick(2);
      chk(rst_o == c, "R8", rst_o, c);
    end

    // R6 delay sweep per channel
    all_good();
    for (int k = 0; k < 4; k++) begin
      for (int d = 0; d < 6; d++) begin
        dly = '0;
        dly[k] = DW'(d);
        uv[k] = 1'b1;
        tick(2);
        uv[k] = 1'b0;
        #1;
        if (d == 0) chk(stat[k] == 1'b1, "R6", stat[k], 1);
        else begin
          tick(d - 1);
          chk(stat[k] == 1'b0, "R6", stat[k], 0);
          tick(1);
          chk(stat[k] == 1'b1, "R6", stat[k], 1);
        end
      end
    end

    // R7 immediate drop and restart of delay count
    dly = '0; dly[1] = DW'(4);
    uv[1] = 1'b1; tick(1); uv[1] = 1'b0;
    tick(6);
    chk(stat[1] == 1'b1, "R7", stat[1], 1);
    uv[1] = 1'b1; #1;
    chk(stat[1] == 1'b0, "R7", stat[1], 0);
    tick(1);
    uv[1] = 1'b0;
    tick(3);
    chk(stat[1] == 1'b0, "R7", stat[1], 0);
    tick(1);
    chk(stat[1] == 1'b1, "R7", stat[1], 1);
    en[1] = 1'b0; #1;
    chk(stat[1] == 1'b0, "R7", stat[1], 0);
    en[1] = 1'b1;
    dly = '0;

    // R9 timeout sweep
    for (int t = 0; t < 7; t++) begin
      tmo = TW'(t);
      mrb_n = 1'b0; tick(1); mrb_n = 1'b1;
      tick(t);
      chk(rst_o == 1'b1, "R9", rst_o, 1);
      tick(1);
      chk(rst_o == 1'b0, "R9", rst_o, 0); chk_pol();
    end

    // R9 cause returning mid-timeout restarts the count
    tmo = TW'(5);
    mrb_n = 1'b0; tick(1); mrb_n = 1'b1;
    tick(3);
    mrb_n = 1'b0; #1;
    chk(rst_o == 1'b1, "R9", rst_o, 1);
    tick(1); mrb_n = 1'b1;
    tick(5);
    chk(rst_o == 1'b1, "R9", rst_o, 1);
    tick(1);
    chk(rst_o == 1'b0, "R9", rst_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule